// File: doc/BRIEF.md
# DRAM-Protocol SRAM Bridge

This block lets a static RAM stand in for a 1M x 1 multiplexed-address dynamic RAM. The legacy host drives active-low row strobe, column strobe and write enable, a 10-bit shared address bus, and separate single-bit data input and output lines. The bridge latches the upper address half on the row strobe's falling edge. It joins that half with the lower half taken on the column strobe's falling edge to form a flat 20-bit SRAM address. It then issues a one-cycle write or a held read to the SRAM.

All three strobes are oversampled by the bridge's own clock through two-flop synchronisers, and edges are found by comparing successive samples. The data output comes with an output-enable so that it can share a net with the data input. Refresh cycles do not touch the SRAM. These are row-only cycles, and cycles in which the column strobe falls first or in the same sample as the row strobe.

Top module: `dram_sram_bridge`

## Requirements
- R1: After reset, sram_ce_no, sram_we_no and sram_oe_no are high (1) and dout_oe_o is low (0).
- R2: sram_addr_o is {row, col}. The row is the value of addr_i at the sampled falling edge of ras_ni and fills bits [19:10]. The column is the value of addr_i at the sampled falling edge of cas_ni and fills bits [9:0].
- R3: If we_ni is low when cas_ni falls while ras_ni is held low, sram_ce_no and sram_we_no go low together for exactly one clock. sram_wdata_o then equals din_i as sampled at that edge.
- R4: If we_ni is high when cas_ni falls while ras_ni is held low, sram_ce_no and sram_oe_no go low and dout_oe_o goes high. dout_o then carries the SRAM word at {row, col} for as long as cas_ni stays low.
- R5: After cas_ni rises, dout_oe_o returns low and sram_ce_no and sram_oe_no return high within 4 clocks.
- R6: A cycle in which ras_ni falls and rises with cas_ni held high (row-only refresh) produces no SRAM strobe and changes no stored word.
- R7: A cas_ni fall while ras_ni is high (column-before-row refresh) produces no SRAM strobe and leaves dout_oe_o low.
- R8: If cas_ni and ras_ni fall in the same sampled clock, the cycle is treated as a refresh, with no SRAM strobe and dout_oe_o low.
- R9: sram_we_no is never low while sram_ce_no is high, and sram_we_no and sram_oe_no are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low, asynchronous |
| cas_ni | input | 1 | Column strobe, active low, asynchronous |
| we_ni | input | 1 | Write enable, active low, asynchronous |
| addr_i | input | 10 | Multiplexed row/column address |
| din_i | input | 1 | Write data from host |
| dout_o | output | 1 | Read data to host |
| dout_oe_o | output | 1 | Drive enable for dout_o (tri-state control) |
| sram_addr_o | output | 20 | Flat SRAM word address |
| sram_ce_no | output | 1 | SRAM chip enable, active low |
| sram_we_no | output | 1 | SRAM write strobe, active low |
| sram_oe_no | output | 1 | SRAM output enable, active low |
| sram_wdata_o | output | 1 | SRAM write data |
| sram_rdata_i | input | 1 | SRAM read data |

## Verification
Row capture and column capture can land in the same sampled clock when the host drops both strobes between two clock edges. The bench provokes this by moving ras_ni and cas_ni on the same falling clock edge. It then judges that no SRAM strobe appears and that the output enable stays low. The bench also interleaves row-only and column-first refresh cycles between random writes. A read-back against a bench-side reference store then confirms that no refresh disturbed memory.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_HOLD = 2'd2,
    ST_RD   = 2'd3
  } dsb_state_e;
endpackage

// File: rtl/dsb_sync.sv
module dsb_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  // strobes idle high
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign sync_o[g] = s2_q;
    assign prev_o[g] = s3_q;
  end
endmodule

// File: rtl/dsb_addr.sv
module dsb_addr #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  localparam int AW = ROW_W + COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ROW_W-1:0] addr_i,
  input  logic             din_i,
  input  logic             row_en_i,
  input  logic             col_en_i,
  output logic [AW-1:0]    sram_addr_o,
  output logic             wdata_o
);
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             din_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_q <= '0;
    else if (row_en_i) row_q <= addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      din_q <= 1'b0;
    end else if (col_en_i) begin
      col_q <= addr_i[COL_W-1:0];
      din_q <= din_i;
    end
  end

  assign sram_addr_o = {row_q, col_q};
  assign wdata_o     = din_q;

  p_row_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_en_i |=> $stable(row_q));
  p_col_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !col_en_i |=> $stable(col_q));
endmodule

// File: rtl/dsb_ctrl.sv
module dsb_ctrl
  import dsb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_s_i,
  input  logic ras_p_i,
  input  logic cas_s_i,
  input  logic cas_p_i,
  input  logic we_s_i,
  output logic col_en_o,
  output logic ce_no,
  output logic we_no,
  output logic oe_no
);
  dsb_state_e state_q, state_d;
  logic cas_fall, cas_rise, access;

  assign cas_fall = cas_p_i & ~cas_s_i;
  assign cas_rise = ~cas_p_i & cas_s_i;
  // row strobe must already be low in the previous sample; coincident edges count as refresh
  assign access   = cas_fall & ~ras_p_i & ~ras_s_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (access) state_d = we_s_i ? ST_RD : ST_WR;
      ST_WR:   state_d = ST_HOLD;
      ST_HOLD: if (cas_rise) state_d = ST_IDLE;
      ST_RD:   if (cas_rise) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign col_en_o = (state_q == ST_IDLE) & access;
  assign ce_no    = !((state_q == ST_WR) || (state_q == ST_RD));
  assign we_no    = !(state_q == ST_WR);
  assign oe_no    = !(state_q == ST_RD);

  p_wr_one_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |=> we_no);
  p_we_needs_ce_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !ce_no);
  p_no_oe_we_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !oe_no));
  p_rd_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_no && cas_rise) |=> (oe_no && ce_no));
  p_cbr_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_no && cas_fall && ras_p_i) |=> ce_no);
endmodule

// File: rtl/dram_sram_bridge.sv
module dram_sram_bridge #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  localparam int AW = ROW_W + COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic [ROW_W-1:0] addr_i,
  input  logic             din_i,
  output logic             dout_o,
  output logic             dout_oe_o,
  output logic [AW-1:0]    sram_addr_o,
  output logic             sram_ce_no,
  output logic             sram_we_no,
  output logic             sram_oe_no,
  output logic             sram_wdata_o,
  input  logic             sram_rdata_i
);
  localparam int NSTB = 3;
  localparam int I_RAS = 0, I_CAS = 1, I_WE = 2;

  logic [NSTB-1:0] stb_s, stb_p;
  logic            row_en, col_en;

  dsb_sync #(.W(NSTB)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({we_ni, cas_ni, ras_ni}),
    .sync_o  (stb_s),
    .prev_o  (stb_p)
  );

  assign row_en = stb_p[I_RAS] & ~stb_s[I_RAS];

  dsb_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ras_s_i  (stb_s[I_RAS]),
    .ras_p_i  (stb_p[I_RAS]),
    .cas_s_i  (stb_s[I_CAS]),
    .cas_p_i  (stb_p[I_CAS]),
    .we_s_i   (stb_s[I_WE]),
    .col_en_o (col_en),
    .ce_no    (sram_ce_no),
    .we_no    (sram_we_no),
    .oe_no    (sram_oe_no)
  );

  dsb_addr #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .din_i       (din_i),
    .row_en_i    (row_en),
    .col_en_i    (col_en),
    .sram_addr_o (sram_addr_o),
    .wdata_o     (sram_wdata_o)
  );

  assign dout_oe_o = ~sram_oe_no;
  assign dout_o    = dout_oe_o & sram_rdata_i;

  p_addr_stable_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_ce_no && $past(!sram_ce_no) |-> $stable(sram_addr_o));
  p_no_drive_ras_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_ce_no && stb_p[I_RAS]) |=> sram_ce_no);
endmodule

// File: tb/dram_sram_bridge_tb_top.sv
module dram_sram_bridge_tb_top;
  localparam int ROW_W = 10, COL_W = 10, AW = 20, NRND = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [ROW_W-1:0] addr = '0;
  logic dout, dout_oe, s_ce_n, s_we_n, s_oe_n, s_wdata, s_rdata;
  logic [AW-1:0] s_addr;

  int n_chk = 0, n_fail = 0, n_wr = 0, n_acc = 0;
  logic [AW-1:0] last_wr_addr;
  logic          last_wr_data;
  bit mem [int];
  bit ref_mem [int];

  always #5 clk = ~clk;

  dram_sram_bridge #(.ROW_W(ROW_W), .COL_W(COL_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n),
    .addr_i(addr), .din_i(din), .dout_o(dout), .dout_oe_o(dout_oe),
    .sram_addr_o(s_addr), .sram_ce_no(s_ce_n), .sram_we_no(s_we_n),
    .sram_oe_no(s_oe_n), .sram_wdata_o(s_wdata), .sram_rdata_i(s_rdata)
  );

  // SRAM model and strobe monitor
  always @(posedge clk) begin
    if (rst_n && !s_ce_n) begin
      n_acc++;
      if (!s_we_n) begin
        n_wr++;
        mem[int'(s_addr)] = s_wdata;
        last_wr_addr = s_addr;
        last_wr_data = s_wdata;
      end
    end
  end
  always @(negedge clk) s_rdata <= mem.exists(int'(s_addr)) ? mem[int'(s_addr)] : 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [9:0] row, input logic [9:0] col, input bit d, input string req);
    int w0 = n_wr;
    addr = row; nclk(2); ras_n = 1'b0; nclk(5);
    addr = col; we_n = 1'b0; din = d; nclk(1); cas_n = 1'b0; nclk(6);
    chk(n_wr == w0 + 1, {req, " one-cycle write strobe"}, n_wr - w0, 1);
    chk(last_wr_addr == {row, col} && last_wr_data == d, {req, " write addr/data"},
        {last_wr_addr, 3'b0, last_wr_data}, {row, col, 3'b0, d});
    cas_n = 1'b1; we_n = 1'b1; nclk(5); ras_n = 1'b1; nclk(5);
    ref_mem[int'({row, col})] = d;
  endtask

  task automatic do_read(input logic [9:0] row, input logic [9:0] col, input string req);
    bit e = ref_mem.exists(int'({row, col})) ? ref_mem[int'({row, col})] : 1'b0;
    addr = row; nclk(2); ras_n = 1'b0; nclk(5);
    addr = col; we_n = 1'b1; nclk(1); cas_n = 1'b0; nclk(6);
    chk(dout_oe && !s_ce_n && !s_oe_n, {req, " R4 read drive"}, {dout_oe, s_ce_n, s_oe_n}, 3'b100);
    chk(s_addr == {row, col}, {req, " R2 address"}, s_addr, {row, col});
    chk(dout == e, {req, " R4 read data"}, dout, e);
    cas_n = 1'b1; nclk(4);
    chk(!dout_oe && s_ce_n && s_oe_n, {req, " R5 release"}, {dout_oe, s_ce_n, s_oe_n}, 3'b011);
    ras_n = 1'b1; nclk(5);
  endtask

  task automatic ras_only(input logic [9:0] row);
    int a0 = n_acc;
    addr = row; nclk(2); ras_n = 1'b0; nclk(8); ras_n = 1'b1; nclk(5);
    chk(n_acc == a0, "R6 row-only refresh no strobe", n_acc - a0, 0);
  endtask

  task automatic cbr();
    int a0 = n_acc;
    cas_n = 1'b0; nclk(5); ras_n = 1'b0; nclk(8);
    chk(n_acc == a0 && !dout_oe, "R7 column-first refresh ignored", n_acc - a0, 0);
    ras_n = 1'b1; nclk(3); cas_n = 1'b1; nclk(5);
  endtask

  task automatic coincident();
    int a0 = n_acc;
    addr = 10'h155; we_n = 1'b0; din = 1'b1;
    nclk(2); ras_n = 1'b0; cas_n = 1'b0; nclk(8);
    chk(n_acc == a0 && !dout_oe, "R8 coincident strobes treated as refresh", n_acc - a0, 0);
    cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; nclk(5);
  endtask

  initial begin
    logic [9:0] rows [NRND];
    logic [9:0] cols [NRND];
    nclk(3);
    chk(s_ce_n && s_we_n && s_oe_n && !dout_oe, "R1 reset state",
        {s_ce_n, s_we_n, s_oe_n, dout_oe}, 4'b1110);
    rst_n = 1'b1; nclk(3);
    chk(s_ce_n && s_we_n && s_oe_n && !dout_oe, "R1 idle after reset",
        {s_ce_n, s_we_n, s_oe_n, dout_oe}, 4'b1110);

    do_write(10'h3FF, 10'h000, 1'b1, "R3 corner");
    do_write(10'h000, 10'h3FF, 1'b1, "R3 corner");
    do_read(10'h3FF, 10'h000, "R2 corner");
    do_read(10'h000, 10'h3FF, "R2 corner");
    do_read(10'h2AA, 10'h155, "R4 unwritten");
    ras_only(10'h3FF);
    do_read(10'h3FF, 10'h000, "R6 data kept");
    cbr();
    coincident();
    do_read(10'h155, 10'h155, "R8 no write");

    for (int i = 0; i < NRND; i++) begin
      rows[i] = 10'($urandom);
      cols[i] = 10'($urandom);
      do_write(rows[i], cols[i], 1'($urandom), "R3 random");
      if (i % 3 == 0) ras_only(rows[i]);
      if (i % 5 == 0) cbr();
      if (i % 7 == 0) coincident();
    end
    for (int i = 0; i < NRND; i++) do_read(rows[i], cols[i], "R4 random");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule